// File: doc/BRIEF.md
# Data-Strobe Line Codec

This block sits between a 2-bit-per-cycle internal bit stream and the two-wire data-strobe signalling of a 100 Mb/s serial cable port, with the core clock running at 50 MHz. On the transmit side it puts each bit on the data wire as plain NRZ. It also drives a strobe wire that inverts only when a bit repeats the one before it. As a result, the XOR of data and strobe changes on every bit period. Strobe leaves on pair A and data on pair B, and one driver-enable output per pair releases the port while transmission is off.

On the receive side the crossed cable delivers data on pair A and strobe on pair B, each as two samples per cycle with the earlier sample in the upper bit. The block rebuilds 2-bit words and locks the word boundary to the data-XOR-strobe parity. It raises a valid flag while the line is active and drops it after four bit periods with no edge on either wire.

Top module: `ds_link_codec`

## Requirements
- R1: While reset is high and on the first cycle after it, `a_tx`, `b_tx`, `a_oe`, `b_oe`, `rx_bits` and `rx_valid` are all zero.
- R2: One cycle after a cycle with `tx_en` high, `b_tx` equals the `tx_bits` of that cycle (NRZ data).
- R3: Each strobe sample equals the previous strobe sample inverted when its data bit equals the previous data bit, and equals the previous strobe sample otherwise. Data XOR strobe therefore changes on every bit period, including across word boundaries.
- R4: Index 1 of every 2-bit word is the earlier bit on the line: `tx_bits[1]` goes out before `tx_bits[0]`, and `a_rx[1]`/`b_rx[1]` are the earlier samples.
- R5: One cycle after a cycle with `tx_en` low, `a_tx` and `b_tx` are zero and the previous data/strobe reference returns to 0/0. The first word after re-enabling is therefore coded against 0/0.
- R6: `a_oe` and `b_oe` equal `tx_en` delayed by one cycle.
- R7: When the earlier receive sample has odd data-XOR-strobe parity, or both samples have even parity, `rx_bits` one cycle later equals `a_rx` of that cycle.
- R8: When the earlier sample has even parity and the later one odd, the word straddles cycles: `rx_bits` one cycle later equals {previous cycle's `a_rx[0]`, current `a_rx[1]`}.
- R9: `rx_valid` is high one cycle after a cycle in which at least one of the last four bit periods showed a change on either receive wire, compared with the sample before it. It is low once four consecutive bit periods have shown no change. After reset the line counts as already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, two bit periods per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| tx_bits | input | 2 | Bits to send, index 1 first |
| a_tx | output | 2 | Strobe samples driven on pair A |
| b_tx | output | 2 | Data samples driven on pair B |
| a_oe | output | 1 | Pair A driver enable |
| b_oe | output | 1 | Pair B driver enable |
| a_rx | input | 2 | Data samples received on pair A |
| b_rx | input | 2 | Strobe samples received on pair B |
| rx_bits | output | 2 | Recovered bits, index 1 earlier |
| rx_valid | output | 1 | Receive line active |

## Verification
The transmit side is driven with constant zeros, constant ones and alternating bits. Constant input forces the strobe to toggle on every bit, while alternating input must leave it frozen, so a wrong strobe rule shows up in one of these runs. Random words then cover mixed runs and the boundary between words. A transmit-disable gap followed by a word of zeros shows whether the 0/0 reference was restored.

On receive, a looped-back stream exercises the aligned word path. A stream shifted by one idle sample forces the straddling path. Switching the line off shows whether valid drops after exactly four quiet bit periods and not after two or six.

// File: rtl/ds_pkg.sv
package ds_pkg;

    localparam int unsigned LANES = 2;

    typedef logic [LANES-1:0] lane_vec_t;

    typedef struct packed {
        logic d;
        logic s;
    } ds_ref_t;

    localparam ds_ref_t DS_REF_ZERO = '{d: 1'b0, s: 1'b0};

    function automatic logic ds_next_strobe(input ds_ref_t prev, input logic nbit);
        return (nbit == prev.d) ? ~prev.s : prev.s;
    endfunction

    function automatic logic ds_parity(input logic d, input logic s);
        return d ^ s;
    endfunction

endpackage

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
    import ds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  lane_vec_t bits_i,
    output lane_vec_t data_o,
    output lane_vec_t strb_o,
    output logic      oe_o
);

    ds_ref_t   ref_q;
    ds_ref_t   ref_n;
    lane_vec_t data_n;
    lane_vec_t strb_n;

    always_comb begin
        ds_ref_t cur;
        cur    = ref_q;
        data_n = '0;
        strb_n = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            cur.s     = ds_next_strobe(cur, bits_i[i]);
            cur.d     = bits_i[i];
            data_n[i] = cur.d;
            strb_n[i] = cur.s;
        end
        ref_n = cur;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ref_q  <= DS_REF_ZERO;
            data_o <= '0;
            strb_o <= '0;
            oe_o   <= 1'b0;
        end else begin
            ref_q  <= ref_n;
            data_o <= data_n;
            strb_o <= strb_n;
            oe_o   <= 1'b1;
        end
    end

    assert_xor_within_word_R3: assert property (@(posedge clk) disable iff (rst)
        oe_o |-> (ds_parity(data_o[1], strb_o[1]) != ds_parity(data_o[0], strb_o[0])));

    assert_xor_across_words_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && oe_o && $past(oe_o)) |->
            (ds_parity(data_o[1], strb_o[1]) != $past(ds_parity(data_o[0], strb_o[0]))));

    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> (data_o == '0 && strb_o == '0));

endmodule

// File: rtl/ds_idle_timer.sv
module ds_idle_timer
    import ds_pkg::*;
#(
    parameter int unsigned IDLE_BITS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_vec_t edge_i,
    output logic      active_o
);

    localparam int unsigned CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;

    always_comb begin
        cnt_n = cnt_q;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (edge_i[i])
                cnt_n = '0;
            else if (cnt_n != CNT_MAX)
                cnt_n = cnt_n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= CNT_MAX;
            active_o <= 1'b0;
        end else begin
            cnt_q    <= cnt_n;
            active_o <= (cnt_n < CNT_MAX);
        end
    end

endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder
    import ds_pkg::*;
#(
    parameter int unsigned IDLE_BITS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_vec_t data_i,
    input  lane_vec_t strb_i,
    output lane_vec_t bits_o,
    output logic      valid_o
);

    ds_ref_t   last_q;
    lane_vec_t edge_v;
    logic      straddle;

    always_comb begin
        ds_ref_t prev;
        prev = last_q;
        for (int i = LANES - 1; i >= 0; i--) begin
            edge_v[i] = (data_i[i] != prev.d) || (strb_i[i] != prev.s);
            prev.d    = data_i[i];
            prev.s    = strb_i[i];
        end
    end

    assign straddle = !ds_parity(data_i[1], strb_i[1]) && ds_parity(data_i[0], strb_i[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= DS_REF_ZERO;
            bits_o <= '0;
        end else begin
            last_q <= '{d: data_i[0], s: strb_i[0]};
            bits_o <= straddle ? {last_q.d, data_i[1]} : data_i;
        end
    end

    ds_idle_timer #(.IDLE_BITS(IDLE_BITS)) i_idle (
        .clk      (clk),
        .rst      (rst),
        .edge_i   (edge_v),
        .active_o (valid_o)
    );

    assert_valid_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $rose(valid_o)) |-> $past(|edge_v));

    assert_quiet_line_drops_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(edge_v == '0) && $past(!valid_o)) |-> !valid_o);

    assert_straddle_word_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(straddle)) |-> (bits_o[0] == $past(data_i[1])));

    assert_aligned_word_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!straddle)) |-> (bits_o == $past(data_i)));

endmodule

// File: rtl/ds_link_codec.sv
module ds_link_codec
    import ds_pkg::*;
#(
    parameter int unsigned IDLE_BITS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic [1:0] tx_bits,
    output logic [1:0] a_tx,
    output logic [1:0] b_tx,
    output logic       a_oe,
    output logic       b_oe,
    input  logic [1:0] a_rx,
    input  logic [1:0] b_rx,
    output logic [1:0] rx_bits,
    output logic       rx_valid
);

    lane_vec_t enc_data;
    lane_vec_t enc_strb;
    logic      enc_oe;

    ds_tx_encoder i_enc (
        .clk    (clk),
        .rst    (rst),
        .en     (tx_en),
        .bits_i (tx_bits),
        .data_o (enc_data),
        .strb_o (enc_strb),
        .oe_o   (enc_oe)
    );

    // transmit pair mapping: strobe on A, data on B
    assign a_tx = enc_strb;
    assign b_tx = enc_data;
    assign a_oe = enc_oe;
    assign b_oe = enc_oe;

    // receive pair mapping through the crossed cable: data on A, strobe on B
    ds_rx_decoder #(.IDLE_BITS(IDLE_BITS)) i_dec (
        .clk     (clk),
        .rst     (rst),
        .data_i  (a_rx),
        .strb_i  (b_rx),
        .bits_o  (rx_bits),
        .valid_o (rx_valid)
    );

    assert_drivers_on_R6: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> (a_oe && b_oe));

    assert_drivers_off_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!a_oe && !b_oe));

    assert_data_nrz_R2: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> (b_tx == $past(tx_bits)));

endmodule

// File: tb/test_ds_link_codec.sv
module test_ds_link_codec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic [1:0] tx_bits = 2'b00;
    logic [1:0] a_tx, b_tx, rx_bits;
    logic       a_oe, b_oe, rx_valid;
    logic [1:0] drv_a = 2'b00;
    logic [1:0] drv_b = 2'b00;
    logic       loopback = 1'b0;
    logic [1:0] a_rx, b_rx;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_ld = 0, m_ls = 0;
    int m_rd = 0, m_rs = 0;
    int m_quiet = 4;
    logic [1:0] e_a = 0, e_b = 0, e_bits = 0;
    logic e_oe = 0, e_valid = 0;
    logic e_straddle = 0;
    bit   m_live = 0;
    logic [1:0] last_tx_bits = 0;

    always #4 clk = ~clk;

    assign a_rx = loopback ? b_tx : drv_a;
    assign b_rx = loopback ? a_tx : drv_b;

    ds_link_codec i_ds_link_codec (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_bits(tx_bits),
        .a_tx(a_tx), .b_tx(b_tx), .a_oe(a_oe), .b_oe(b_oe),
        .a_rx(a_rx), .b_rx(b_rx), .rx_bits(rx_bits), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // compute expectations for the inputs present now (called at negedge)
    task automatic model_step();
        int d, s, p1, p0, prev_low;
        if (!tx_en) begin
            e_a = 0; e_b = 0; e_oe = 0; m_ld = 0; m_ls = 0;
        end else begin
            for (int k = 1; k >= 0; k--) begin
                d = tx_bits[k];
                s = (d == m_ld) ? 1 - m_ls : m_ls;
                e_b[k] = d[0]; e_a[k] = s[0];
                m_ld = d; m_ls = s;
            end
            e_oe = 1;
        end
        last_tx_bits = tx_bits;
        p1 = a_rx[1] ^ b_rx[1];
        p0 = a_rx[0] ^ b_rx[0];
        prev_low = m_rd;
        e_straddle = (p1 == 0 && p0 == 1);
        e_bits = e_straddle ? {prev_low[0], a_rx[1]} : a_rx;
        for (int k = 1; k >= 0; k--) begin
            if (a_rx[k] != m_rd[0] || b_rx[k] != m_rs[0]) m_quiet = 0;
            else if (m_quiet < 4) m_quiet++;
            m_rd = a_rx[k]; m_rs = b_rx[k];
        end
        e_valid = (m_quiet < 4);
        m_live = 1;
    endtask

    task automatic compare();
        if (!m_live) return;
        chk("R2", b_tx, e_b);
        chk("R4", b_tx[1], e_b[1]);
        chk("R3", a_tx, e_a);
        chk("R6", a_oe, e_oe);
        chk("R6", b_oe, e_oe);
        if (e_straddle) chk("R8", rx_bits, e_bits);
        else            chk("R7", rx_bits, e_bits);
        chk("R9", rx_valid, e_valid);
    endtask

    // one cycle: compare previous, set new inputs, model them
    task automatic cycle(input logic en, input logic [1:0] b);
        @(negedge clk);
        compare();
        tx_en = en; tx_bits = b;
        #1;
        model_step();
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] q_d[$];
        logic [1:0] q_s[$];
        int rld, rls, ds, ss;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {a_tx, b_tx, a_oe, b_oe}, 0);
        chk("R1", {rx_bits, rx_valid}, 0);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", {a_tx, b_tx, a_oe, b_oe, rx_bits, rx_valid}, 0);
        #1 model_step();

        loopback = 1;
        repeat (6) cycle(1, 2'b00);   // strobe toggles every bit
        repeat (6) cycle(1, 2'b11);
        repeat (6) cycle(1, 2'b10);   // strobe frozen
        repeat (40) cycle(1, 2'($urandom));
        repeat (3) cycle(0, 2'b00);   // disable, R5
        @(negedge clk);
        chk("R5", {a_tx, b_tx}, 0);
        compare();
        tx_en = 1; tx_bits = 2'b00;
        #1 model_step();
        @(negedge clk);
        chk("R5", a_tx, 2'b10);      // coded against 0/0 reference
        compare();
        tx_en = 1; tx_bits = 2'b01;
        #1 model_step();
        repeat (10) cycle(1, 2'($urandom));
        // line goes quiet: valid must drop after four bit periods
        repeat (6) cycle(0, 2'b00);
        chk("R9", rx_valid, 0);

        // misaligned stream: one idle sample ahead of encoded bits
        @(negedge clk);
        compare();
        loopback = 0;
        rld = 0; rls = 0;
        q_d.push_back(0); q_s.push_back(0);
        for (int n = 0; n < 60; n++) begin
            ds = $urandom % 2;
            ss = (ds == rld) ? 1 - rls : rls;
            q_d.push_back(ds[1:0]); q_s.push_back(ss[1:0]);
            rld = ds; rls = ss;
        end
        while (q_d.size() >= 2) begin
            drv_a = {q_d[0][0], q_d[1][0]};
            drv_b = {q_s[0][0], q_s[1][0]};
            void'(q_d.pop_front()); void'(q_d.pop_front());
            void'(q_s.pop_front()); void'(q_s.pop_front());
            #1 model_step();
            @(negedge clk);
            compare();
        end
        drv_a = 0; drv_b = 0;
        #1 model_step();
        repeat (4) cycle(0, 2'b00);
        @(negedge clk);
        compare();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule